// File: doc/BRIEF.md
# Configurable Registered Buffer with Parity Check

This block is a clocked register for a bank of command and address lines. On each rising clock edge it captures its inputs and drives them onto registered outputs. A two-bit static configuration picks one of two topologies. In the wide topology, 25 inputs each drive one output. In the paired topology, 14 inputs each drive two outputs. In the paired topology the configuration also picks the device's role in a cascade of two buffers: first or second.

Alongside the data path the block checks even parity. It counts the ones on the module-independent data inputs of a captured word, together with a parity bit from the controller. A parity error pulls the active-low error flag low for two cycles. The flag is modelled as an open-drain output: a low level means drive 0, a high level means release.

In a cascade, the first device does not raise the flag. It passes its registered partial parity to the second device. The second device combines that partial parity with its own captured data and makes the single error decision. Chip-select gating freezes the data bits when both selects are high. The control bits keep updating while the data bits are frozen.

The configuration is decoded as follows. With `cfg_sel[0]`=0 the block is in the wide topology and `cfg_sel[1]` is ignored. With `cfg_sel`=01 it is the first device of a pair, and with `cfg_sel`=11 it is the second.

The error flag is driven by a state machine with three states:
- `ST_CLEAR`: the flag is released.
- `ST_FLAG1`: first cycle of a flagged error.
- `ST_FLAG2`: second cycle of a flagged error.

Its transitions are:
- any state to `ST_FLAG1` on a detected error;
- `ST_FLAG1` to `ST_FLAG2` without one;
- `ST_FLAG2` to `ST_CLEAR` without one;
- `ST_CLEAR` stays in `ST_CLEAR` without one.

Top module: `regbuf_par_top`

## Requirements
- R1: In the wide topology (`cfg_sel[0]`=0), after a capturing edge `q[i]` equals the `din[i]` sampled at that edge for i in 0..24, and `q[27:25]` is 0.
- R2: In the paired topology (`cfg_sel[0]`=1), `q[i]` and `q[i+14]` both equal the captured `din[i]` for i in 0..13, and `din[24:14]` has no effect on `q`.
- R3: An edge where both `cs_n` bits are 1 leaves the data bits of `q` unchanged, while the control bits still load. Data bits are `din[21:0]` in the wide topology and `din[10:0]` in the paired one. Control bits are `din[24:22]` (wide) and `din[13:11]` (paired).
- R4: For a standalone device (wide topology), suppose a word is captured with at least one `cs_n` bit low, and that word has an odd count of ones over `din[21:0]` plus `par_in`. Then `err_n` is 0 after the next edge. A word captured with both selects high is not checked.
- R5: A detected error holds `err_n` low for exactly two cycles. An error detected while the flag is low restarts the two-cycle hold.
- R6: As first device (`cfg_sel`=01), the block drives `ppar_out`. After a capturing edge with a select low, `ppar_out` is the XOR of `din[10:0]` and `par_in`. In this role `err_n` stays 1.
- R7: As second device (`cfg_sel`=11), the block ignores `par_in`. The error decision is the XOR of the captured `din[10:0]` with `ppar_in` sampled at the following edge. When that XOR is 1, `err_n` is 0 after that edge.
- R8: While `rst_n` is low, asynchronously and without a clock edge, `q` is 0, `err_n` is 1 and `ppar_out` is 0.
- R9: Outside the first-device role, `ppar_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 2 | Static configuration: bit 0 selects paired, bit 1 selects second device |
| cs_n | input | 2 | Active-low chip selects; both high freezes the data bits |
| din | input | 25 | Command, address and control inputs |
| par_in | input | 1 | Parity bit from the controller |
| ppar_in | input | 1 | Partial parity from the first device of a pair |
| q | output | 28 | Registered outputs |
| ppar_out | output | 1 | Registered partial parity toward the second device |
| err_n | output | 1 | Active-low parity error flag, open-drain style |

## Verification
`q` and `ppar_out` follow the capturing edge, so the bench checks them at the falling edge right after that edge. `err_n` is due one edge later, stays low through a second edge and is released after a third. The bench therefore follows each vector with idle, deselected cycles and samples `err_n` at the falling edge after each of those three edges. Inputs change only at falling edges, so every sample point is a known whole number of registered edges after its stimulus.

// File: rtl/regbuf_pkg.sv
package regbuf_pkg;

    typedef enum logic [1:0] {
        MODE_WIDE   = 2'd0,
        MODE_PAIR_A = 2'd1,
        MODE_PAIR_B = 2'd2
    } mode_t;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_FLAG1 = 2'd1,
        ST_FLAG2 = 2'd2
    } flag_st_t;

    function automatic mode_t decode_mode(input logic [1:0] sel);
        if (!sel[0])
            return MODE_WIDE;
        else if (sel[1])
            return MODE_PAIR_B;
        else
            return MODE_PAIR_A;
    endfunction

endpackage

// File: rtl/regbuf_capture.sv
module regbuf_capture
    import regbuf_pkg::*;
#(
    parameter int IN_W        = 25,
    parameter int WIDE_DATA   = 22,
    parameter int NARROW_DATA = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mode_t           mode,
    input  logic            cs_act,
    input  logic [IN_W-1:0] din,
    output logic [IN_W-1:0] q_reg
);
    localparam logic [IN_W-1:0] WMASK = {{(IN_W-WIDE_DATA){1'b0}}, {WIDE_DATA{1'b1}}};
    localparam logic [IN_W-1:0] NMASK = {{(IN_W-NARROW_DATA){1'b0}}, {NARROW_DATA{1'b1}}};

    logic [IN_W-1:0] dmask;
    assign dmask = (mode == MODE_WIDE) ? WMASK : NMASK;

    // Data bits load only when selected; control bits always load.
    for (genvar i = 0; i < IN_W; i++) begin : g_bit
        localparam bit CTL_W = (i >= WIDE_DATA);
        localparam bit CTL_N = (i >= NARROW_DATA);
        logic en;
        logic bit_q;
        assign en = cs_act | ((mode == MODE_WIDE) ? CTL_W : CTL_N);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bit_q <= 1'b0;
            else if (en)
                bit_q <= din[i];
        end
        assign q_reg[i] = bit_q;
    end

    AST_GATED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> ((q_reg & $past(dmask)) == ($past(q_reg) & $past(dmask)))); // R3

endmodule

// File: rtl/regbuf_parity.sv
module regbuf_parity
    import regbuf_pkg::*;
#(
    parameter int IN_W        = 25,
    parameter int WIDE_DATA   = 22,
    parameter int NARROW_DATA = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  mode_t           mode,
    input  logic            cs_act,
    input  logic [IN_W-1:0] din,
    input  logic            par_in,
    output logic            chk_valid,
    output logic            chk_par
);
    localparam logic [IN_W-1:0] WMASK = {{(IN_W-WIDE_DATA){1'b0}}, {WIDE_DATA{1'b1}}};
    localparam logic [IN_W-1:0] NMASK = {{(IN_W-NARROW_DATA){1'b0}}, {NARROW_DATA{1'b1}}};

    logic data_x;
    logic fold;

    always_comb begin
        data_x = ^(din & ((mode == MODE_WIDE) ? WMASK : NMASK));
        // The second device of a pair takes the cascaded partial instead of par_in.
        fold   = data_x ^ ((mode == MODE_PAIR_B) ? 1'b0 : par_in);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_valid <= 1'b0;
            chk_par   <= 1'b0;
        end else begin
            chk_valid <= cs_act;
            if (cs_act)
                chk_par <= fold;
        end
    end

endmodule

// File: rtl/regbuf_errflag.sv
module regbuf_errflag
    import regbuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  chk_valid,
    input  logic  chk_par,
    input  logic  ppar_in,
    output logic  err_n
);
    flag_st_t state, state_nx;
    logic     err_cond;

    assign err_cond = chk_valid && (mode != MODE_PAIR_A)
                      && (chk_par ^ ((mode == MODE_PAIR_B) && ppar_in));

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_CLEAR: state_nx = err_cond ? ST_FLAG1 : ST_CLEAR;
            ST_FLAG1: state_nx = err_cond ? ST_FLAG1 : ST_FLAG2;
            ST_FLAG2: state_nx = err_cond ? ST_FLAG1 : ST_CLEAR;
            default:  state_nx = ST_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_CLEAR;
        else
            state <= state_nx;
    end

    always_comb begin
        err_n = (state == ST_CLEAR);
    end

    AST_FLAG_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        err_cond |=> !err_n); // R4
    AST_FLAG_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n && $past(err_n)) |=> !err_n); // R5

endmodule

// File: rtl/regbuf_par_top.sv
module regbuf_par_top
    import regbuf_pkg::*;
#(
    parameter int IN_W        = 25,
    parameter int PAIR_W      = 14,
    parameter int WIDE_DATA   = 22,
    parameter int NARROW_DATA = 11,
    localparam int OUT_W      = (IN_W > 2*PAIR_W) ? IN_W : 2*PAIR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_sel,
    input  logic [1:0]       cs_n,
    input  logic [IN_W-1:0]  din,
    input  logic             par_in,
    input  logic             ppar_in,
    output logic [OUT_W-1:0] q,
    output logic             ppar_out,
    output logic             err_n
);
    mode_t           mode;
    logic            cs_act;
    logic [IN_W-1:0] q_reg;
    logic            chk_valid;
    logic            chk_par;

    assign mode   = decode_mode(cfg_sel);
    assign cs_act = ~&cs_n;

    regbuf_capture #(
        .IN_W(IN_W), .WIDE_DATA(WIDE_DATA), .NARROW_DATA(NARROW_DATA)
    ) u_cap (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cs_act(cs_act),
        .din(din), .q_reg(q_reg)
    );

    regbuf_parity #(
        .IN_W(IN_W), .WIDE_DATA(WIDE_DATA), .NARROW_DATA(NARROW_DATA)
    ) u_par (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cs_act(cs_act),
        .din(din), .par_in(par_in), .chk_valid(chk_valid), .chk_par(chk_par)
    );

    regbuf_errflag u_flag (
        .clk(clk), .rst_n(rst_n), .mode(mode), .chk_valid(chk_valid),
        .chk_par(chk_par), .ppar_in(ppar_in), .err_n(err_n)
    );

    // Output fan-out per topology.
    for (genvar j = 0; j < OUT_W; j++) begin : g_out
        logic w_bit;
        logic n_bit;
        if (j < IN_W) begin : g_w
            assign w_bit = q_reg[j];
        end else begin : g_wz
            assign w_bit = 1'b0;
        end
        if (j < PAIR_W) begin : g_n0
            assign n_bit = q_reg[j];
        end else if (j < 2*PAIR_W) begin : g_n1
            assign n_bit = q_reg[j-PAIR_W];
        end else begin : g_nz
            assign n_bit = 1'b0;
        end
        assign q[j] = (mode == MODE_WIDE) ? w_bit : n_bit;
    end

    assign ppar_out = (mode == MODE_PAIR_A) ? chk_par : 1'b0;

    AST_PAIR_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_WIDE) |-> (q[PAIR_W-1:0] == q[2*PAIR_W-1:PAIR_W])); // R2
    AST_ROLE_A_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PAIR_A) |-> err_n); // R6
    AST_PPAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != MODE_PAIR_A) |-> !ppar_out); // R9

endmodule

// File: tb/regbuf_par_top_test.sv
`timescale 1ns/1ps
module regbuf_par_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_sel = 2'b00;
    logic [1:0]  cs_n = 2'b11;
    logic [24:0] din = '0;
    logic        par_in = 1'b0;
    logic        ppar_in = 1'b0;
    logic [27:0] q;
    logic        ppar_out;
    logic        err_n;

    int n_chk = 0;
    int n_err = 0;
    logic [24:0] m = '0;

    always #2.5 clk = ~clk;

    regbuf_par_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cs_n(cs_n), .din(din),
        .par_in(par_in), .ppar_in(ppar_in), .q(q), .ppar_out(ppar_out), .err_n(err_n)
    );

    // {cs_n, din, par_in, expected error}; wide topology
    localparam logic [28:0] VEC [8] = '{
        {2'b00, 25'h0000000, 1'b0, 1'b0},
        {2'b10, 25'h0000001, 1'b1, 1'b0},
        {2'b01, 25'h0000003, 1'b1, 1'b1},
        {2'b00, 25'h1C00000, 1'b1, 1'b1},
        {2'b00, 25'h03FFFFF, 1'b0, 1'b0},
        {2'b11, 25'h0000007, 1'b0, 1'b0},
        {2'b00, 25'h1555555, 1'b0, 1'b1},
        {2'b00, 25'h0AAAAAA, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference capture per R1..R3
    task automatic model_edge();
        int lim;
        lim = cfg_sel[0] ? 11 : 22;
        for (int i = 0; i < 25; i++)
            if (cs_n != 2'b11 || i >= lim) m[i] = din[i];
    endtask

    function automatic logic [27:0] exp_q();
        if (cfg_sel[0]) return {m[13:0], m[13:0]};
        return {3'b000, m};
    endfunction

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] cfg);
        @(negedge clk);
        rst_n = 1'b0; cfg_sel = cfg; cs_n = 2'b11; din = '0; par_in = 1'b0; ppar_in = 1'b0;
        m = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset(2'b00);
        chk("R8 reset q", {4'h0, q}, 32'h0);
        chk("R8 reset err_n", {31'h0, err_n}, 32'h1);
        chk("R8 reset ppar_out", {31'h0, ppar_out}, 32'h0);

        // Vector walk, wide topology
        for (int v = 0; v < 8; v++) begin
            {cs_n, din, par_in} = VEC[v][28:1];
            step();
            chk((VEC[v][28:27] == 2'b11) ? "R3 wide gated q" : "R1 wide q", {4'h0, q}, {4'h0, exp_q()});
            chk("R9 ppar_out wide", {31'h0, ppar_out}, 32'h0);
            cs_n = 2'b11;
            step();
            chk("R4 err_n after check edge", {31'h0, err_n}, {31'h0, ~VEC[v][0]});
            step();
            chk("R5 err_n second cycle", {31'h0, err_n}, {31'h0, ~VEC[v][0]});
            step();
            chk("R5 err_n released", {31'h0, err_n}, 32'h1);
        end

        // R8 asynchronous reset without a clock edge
        @(negedge clk);
        #1 rst_n = 1'b0;
        #0.5;
        chk("R8 async q", {4'h0, q}, 32'h0);
        chk("R8 async err_n", {31'h0, err_n}, 32'h1);
        m = '0;

        // R5 back-to-back errors restart the hold
        do_reset(2'b00);
        cs_n = 2'b00; din = 25'h1; par_in = 1'b0;
        step();
        din = 25'h7;
        step();
        cs_n = 2'b11;
        chk("R5 first error", {31'h0, err_n}, 32'h0);
        step();
        chk("R5 restarted hold a", {31'h0, err_n}, 32'h0);
        step();
        chk("R5 restarted hold b", {31'h0, err_n}, 32'h0);
        step();
        chk("R5 released after restart", {31'h0, err_n}, 32'h1);

        // First device of a pair
        do_reset(2'b01);
        cs_n = 2'b01; din = {11'h7FF, 14'h2A5C}; par_in = 1'b0;
        step();
        chk("R2 pair fan-out", {4'h0, q}, {4'h0, 28'({14'h2A5C, 14'h2A5C})});
        chk("R6 ppar_out", {31'h0, ppar_out}, 32'h1);
        cs_n = 2'b11;
        step();
        chk("R6 err_n released a", {31'h0, err_n}, 32'h1);
        din = {11'h000, 14'h3FFF};
        step();
        chk("R6 err_n released b", {31'h0, err_n}, 32'h1);
        chk("R3 pair gated q", {4'h0, q}, {4'h0, 28'({14'h3A5C, 14'h3A5C})});

        // Second device of a pair
        do_reset(2'b11);
        cs_n = 2'b10; din = 25'h0000007; par_in = 1'b0; ppar_in = 1'b1;
        step();
        chk("R9 ppar_out second", {31'h0, ppar_out}, 32'h0);
        cs_n = 2'b11;
        step();
        chk("R7 even with partial, par_in ignored", {31'h0, err_n}, 32'h1);
        cs_n = 2'b10; par_in = 1'b1; ppar_in = 1'b0;
        step();
        cs_n = 2'b11;
        step();
        chk("R7 odd with partial", {31'h0, err_n}, 32'h0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule